// File: doc/BRIEF.md
# Multi-Lane Masked Vector Execution Unit

This unit performs element-wise integer arithmetic on whole vector registers using several identical lanes. Element e of every vector register belongs to lane e mod LANES. All lanes work on one group of LANES consecutive elements per cycle under one shared control word, so no data crosses between lanes. The unit holds its own register file of eight 32-element, 32-bit vector registers, four 32-bit mask registers and a vector-length register. The vector-length register sets how many leading elements each arithmetic or compare command touches.

Commands arrive over a valid/ready handshake. The operations are add, subtract and multiply, each in a vector-vector or scalar-vector form. There is also a not-equal compare that writes one mask bit per element, a single-element write, and a vector-length set. Arithmetic can be predicated by a chosen mask register, or run with every element enabled. Read ports show any vector element, any mask register and the current vector length.

The sequencer has three states. ST_IDLE accepts a command. It moves to ST_RUN, or to ST_DONE directly when the command has zero element groups. ST_RUN writes one group per cycle and moves to ST_DONE after the last group. ST_DONE raises `done` for one cycle and returns to ST_IDLE.

Top module: `vec_lane_unit`

## Requirements
- R1: Each arithmetic or compare command occupies ceil(VL/4) cycles in ST_RUN. `done` is high in the cycle after the final group is written. Counted from the accepting clock edge, `done` is seen in cycle ceil(VL/4)+1. A single-element write and a length set each take one group, so `done` is seen in cycle 2.
- R2: Vector-vector forms (`cmd_sfrm`=0) produce the following element-wise results modulo 2^32. Opcode 0 gives vs1+vs2. Opcode 1 gives vs1-vs2. Opcode 2 gives the low 32 bits of vs1*vs2.
- R3: Scalar-vector forms (`cmd_sfrm`=1) use `cmd_scalar` in place of every vs1 element.
- R4: Opcode 5 sets the vector length to `cmd_scalar`, clamped to 32. `vl_now` shows the current length.
- R5: Elements at index VL and above are left unchanged in the destination vector and in the destination mask.
- R6: Opcode 3 compares operand a (vs1, or the scalar when `cmd_sfrm`=1) with vs2. For every element below VL it sets bit e of mask `cmd_mdst` to 1 when the two differ and to 0 when they are equal.
- R7: With `cmd_nomask`=0, arithmetic writes element e only when bit e of mask `cmd_msrc` is 1, and other elements keep their value. With `cmd_nomask`=1, all elements below VL are written whatever the mask holds.
- R8: Opcode 4 writes `cmd_scalar` into element `cmd_eidx` of register `cmd_vd`, whatever the value of VL.
- R9: `cmd_ready` is high only in ST_IDLE. A command offered while the unit is busy has no effect. `done` lasts exactly one cycle.
- R10: After reset, every vector element and mask bit is zero, VL is 32, `cmd_ready` is 1 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command taken at this edge |
| cmd_op | input | 3 | Opcode (0 add, 1 sub, 2 mul, 3 compare-not-equal, 4 element write, 5 set length) |
| cmd_sfrm | input | 1 | Scalar replaces first vector operand |
| cmd_nomask | input | 1 | Treat all mask bits as set |
| cmd_vd | input | 3 | Destination vector register |
| cmd_vs1 | input | 3 | First source vector register |
| cmd_vs2 | input | 3 | Second source vector register |
| cmd_msrc | input | 2 | Predicate mask register |
| cmd_mdst | input | 2 | Compare destination mask register |
| cmd_scalar | input | 32 | Scalar operand, element data or length |
| cmd_eidx | input | 5 | Element index for the single-element write |
| done | output | 1 | One-cycle completion pulse |
| vl_now | output | 6 | Current vector length |
| rd_vsel | input | 3 | Read port vector register select |
| rd_eidx | input | 5 | Read port element index |
| rd_elem | output | 32 | Selected vector element |
| rd_msel | input | 2 | Read port mask register select |
| rd_mask | output | 32 | Selected mask register |

## Verification
Two events can fall in the same cycle: a new command offered on the handshake, and a group write or `done` pulse from a command still in progress. The bench provokes this by holding `cmd_valid` high with a length-set command during a full-length add, across several ST_RUN cycles. It then judges the outcome at the ports. `cmd_ready` must stay low, `vl_now` must be unchanged after `done`, and the add's destination must match the model. Length-edge cases (VL of 13, 0 and a clamped 100) and masked writes are checked against a model of the register file that the bench keeps independently.

// File: rtl/vlu_pkg.sv
package vlu_pkg;
    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_MUL   = 3'd2,
        OP_CMPNE = 3'd3,
        OP_SETEL = 3'd4,
        OP_SETVL = 3'd5
    } vop_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } vst_e;
endpackage

// File: rtl/vlu_lane_alu.sv
module vlu_lane_alu
    import vlu_pkg::*;
#(
    parameter int EW = 32
) (
    input  logic [2:0]    op,
    input  logic [EW-1:0] opa,
    input  logic [EW-1:0] opb,
    output logic [EW-1:0] res,
    output logic          neq
);
    always_comb begin
        case (op)
            OP_ADD:  res = opa + opb;
            OP_SUB:  res = opa - opb;
            OP_MUL:  res = opa * opb;
            default: res = '0;
        endcase
        neq = (opa != opb);
    end
endmodule

// File: rtl/vlu_seq.sv
module vlu_seq
    import vlu_pkg::*;
#(
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [SW-1:0] steps,
    output logic          ready,
    output logic          run,
    output logic          done,
    output logic [SW-1:0] grp
);
    vst_e          st, st_nxt;
    logic [SW-1:0] steps_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            steps_q <= '0;
            grp     <= '0;
        end else begin
            st <= st_nxt;
            if (start) begin
                steps_q <= steps;
                grp     <= '0;
            end else if (st == ST_RUN) begin
                grp <= grp + 1'b1;
            end
        end
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: if (start) st_nxt = (steps == '0) ? ST_DONE : ST_RUN;
            ST_RUN:  if (grp == steps_q - 1'b1) st_nxt = ST_DONE;
            ST_DONE: st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        ready = (st == ST_IDLE);
        run   = (st == ST_RUN);
        done  = (st == ST_DONE);
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    // R9
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n) run |-> !ready);
    // R1
    done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(run) |-> done);
    // R1
    grp_range_chk: assert property (@(posedge clk) disable iff (!rst_n) run |-> (grp < steps_q));
endmodule

// File: rtl/vec_lane_unit.sv
module vec_lane_unit
    import vlu_pkg::*;
#(
    parameter int EW    = 32,
    parameter int LANES = 4,
    parameter int MAXVL = 32,
    parameter int NVREG = 8,
    parameter int NMREG = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    output logic                     cmd_ready,
    input  logic [2:0]               cmd_op,
    input  logic                     cmd_sfrm,
    input  logic                     cmd_nomask,
    input  logic [$clog2(NVREG)-1:0] cmd_vd,
    input  logic [$clog2(NVREG)-1:0] cmd_vs1,
    input  logic [$clog2(NVREG)-1:0] cmd_vs2,
    input  logic [$clog2(NMREG)-1:0] cmd_msrc,
    input  logic [$clog2(NMREG)-1:0] cmd_mdst,
    input  logic [EW-1:0]            cmd_scalar,
    input  logic [$clog2(MAXVL)-1:0] cmd_eidx,
    output logic                     done,
    output logic [$clog2(MAXVL+1)-1:0] vl_now,
    input  logic [$clog2(NVREG)-1:0] rd_vsel,
    input  logic [$clog2(MAXVL)-1:0] rd_eidx,
    output logic [EW-1:0]            rd_elem,
    input  logic [$clog2(NMREG)-1:0] rd_msel,
    output logic [MAXVL-1:0]         rd_mask
);
    localparam int NGRP = MAXVL / LANES;
    localparam int VLW  = $clog2(MAXVL + 1);
    localparam int EIW  = $clog2(MAXVL);
    localparam int VRW  = $clog2(NVREG);
    localparam int MRW  = $clog2(NMREG);
    localparam int SW   = $clog2(NGRP + 1);

    logic [EW-1:0]    vrf [NVREG][MAXVL];
    logic [MAXVL-1:0] mrf [NMREG];
    logic [VLW-1:0]   vl_q;

    logic [2:0]     op_q;
    logic           sfrm_q, nomask_q;
    logic [VRW-1:0] vd_q, vs1_q, vs2_q;
    logic [MRW-1:0] msrc_q, mdst_q;
    logic [EW-1:0]  scal_q;
    logic [EIW-1:0] eidx_q;

    logic          start, run;
    logic [SW-1:0] steps, grp;

    assign start = cmd_valid && cmd_ready;

    always_comb begin
        if (cmd_op <= OP_CMPNE)
            steps = SW'((int'(vl_q) + LANES - 1) / LANES);
        else
            steps = SW'(1);
    end

    vlu_seq #(.SW(SW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .steps(steps),
        .ready(cmd_ready), .run(run), .done(done), .grp(grp)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= '0; sfrm_q <= 1'b0; nomask_q <= 1'b0;
            vd_q <= '0; vs1_q <= '0; vs2_q <= '0;
            msrc_q <= '0; mdst_q <= '0; scal_q <= '0; eidx_q <= '0;
        end else if (start) begin
            op_q <= cmd_op; sfrm_q <= cmd_sfrm; nomask_q <= cmd_nomask;
            vd_q <= cmd_vd; vs1_q <= cmd_vs1; vs2_q <= cmd_vs2;
            msrc_q <= cmd_msrc; mdst_q <= cmd_mdst;
            scal_q <= cmd_scalar; eidx_q <= cmd_eidx;
        end
    end

    logic [LANES-1:0] act_v, neq_v;
    logic [EW-1:0]    res_v  [LANES];
    logic [EIW-1:0]   epos_v [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [VLW:0]  pos;
        logic [EW-1:0] opa, opb;
        assign pos       = (VLW+1)'(grp) * (VLW+1)'(LANES) + (VLW+1)'(l);
        assign act_v[l]  = pos < {1'b0, vl_q};
        assign epos_v[l] = pos[EIW-1:0];
        assign opa       = sfrm_q ? scal_q : vrf[vs1_q][epos_v[l]];
        assign opb       = vrf[vs2_q][epos_v[l]];
        vlu_lane_alu #(.EW(EW)) u_alu (
            .op(op_q), .opa(opa), .opb(opb), .res(res_v[l]), .neq(neq_v[l])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int v = 0; v < NVREG; v++)
                for (int e = 0; e < MAXVL; e++)
                    vrf[v][e] <= '0;
            for (int m = 0; m < NMREG; m++)
                mrf[m] <= '0;
            vl_q <= VLW'(MAXVL);
        end else if (run) begin
            if (op_q == OP_SETEL) begin
                vrf[vd_q][eidx_q] <= scal_q;
            end else if (op_q == OP_SETVL) begin
                vl_q <= (scal_q > EW'(MAXVL)) ? VLW'(MAXVL) : scal_q[VLW-1:0];
            end else if (op_q == OP_CMPNE) begin
                for (int l = 0; l < LANES; l++)
                    if (act_v[l]) mrf[mdst_q][epos_v[l]] <= neq_v[l];
            end else if (op_q <= OP_MUL) begin
                for (int l = 0; l < LANES; l++)
                    if (act_v[l] && (nomask_q || mrf[msrc_q][epos_v[l]]))
                        vrf[vd_q][epos_v[l]] <= res_v[l];
            end
        end
    end

    assign vl_now  = vl_q;
    assign rd_elem = vrf[rd_vsel][rd_eidx];
    assign rd_mask = mrf[rd_msel];

    // R9
    no_reaccept_chk: assert property (@(posedge clk) disable iff (!rst_n) start |=> !cmd_ready);
    // R4
    vl_cap_chk: assert property (@(posedge clk) disable iff (!rst_n) vl_q <= VLW'(MAXVL));
    // R4
    vl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && op_q == OP_SETVL) |=> $stable(vl_q));
endmodule

// File: tb/vec_lane_unit_bench.sv
module vec_lane_unit_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, cmd_valid, cmd_ready, cmd_sfrm, cmd_nomask, done;
    logic [2:0]  cmd_op, cmd_vd, cmd_vs1, cmd_vs2, rd_vsel;
    logic [1:0]  cmd_msrc, cmd_mdst, rd_msel;
    logic [31:0] cmd_scalar, rd_elem, rd_mask;
    logic [4:0]  cmd_eidx, rd_eidx;
    logic [5:0]  vl_now;

    vec_lane_unit u_vec_lane_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_sfrm(cmd_sfrm), .cmd_nomask(cmd_nomask),
        .cmd_vd(cmd_vd), .cmd_vs1(cmd_vs1), .cmd_vs2(cmd_vs2),
        .cmd_msrc(cmd_msrc), .cmd_mdst(cmd_mdst), .cmd_scalar(cmd_scalar),
        .cmd_eidx(cmd_eidx), .done(done), .vl_now(vl_now),
        .rd_vsel(rd_vsel), .rd_eidx(rd_eidx), .rd_elem(rd_elem),
        .rd_msel(rd_msel), .rd_mask(rd_mask)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;
    logic [31:0] mv [8][32];
    logic [31:0] mm [4];
    int mvl = 32;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model(input int op, input bit sf, input bit um, input int vd, input int vs1,
                         input int vs2, input int ms, input int md, input logic [31:0] sc, input int ei);
        for (int e = 0; e < 32; e++) begin
            logic [31:0] a, b;
            if (e >= mvl || op > 3) break;
            a = sf ? sc : mv[vs1][e];
            b = mv[vs2][e];
            if (op == 3) mm[md][e] = (a != b);
            else if (um || mm[ms][e]) mv[vd][e] = (op == 0) ? a + b : (op == 1) ? a - b : a * b;
        end
        if (op == 4) mv[vd][ei] = sc;
        if (op == 5) mvl = (sc > 32) ? 32 : int'(sc);
    endtask

    task automatic do_op(input int op, input bit sf, input bit um, input int vd, input int vs1,
                         input int vs2, input int ms, input int md, input logic [31:0] sc, input int ei,
                         input string req);
        int lat, exp_lat;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_op = 3'(op); cmd_sfrm = sf; cmd_nomask = um; cmd_vd = 3'(vd); cmd_vs1 = 3'(vs1);
        cmd_vs2 = 3'(vs2); cmd_msrc = 2'(ms); cmd_mdst = 2'(md); cmd_scalar = sc; cmd_eidx = 5'(ei);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        exp_lat = (op <= 3) ? (mvl + 3) / 4 + 1 : 2;
        chk(req, "latency", 32'(lat), 32'(exp_lat));
        model(op, sf, um, vd, vs1, vs2, ms, md, sc, ei);
    endtask

    task automatic check_vec(input int v, input string req);
        int bad_e = -1;
        logic [31:0] got = '0;
        for (int e = 0; e < 32; e++) begin
            rd_vsel = 3'(v); rd_eidx = 5'(e);
            #1;
            if (rd_elem !== mv[v][e] && bad_e < 0) begin bad_e = e; got = rd_elem; end
        end
        if (bad_e < 0) chk(req, $sformatf("v%0d", v), 32'd0, 32'd0);
        else chk(req, $sformatf("v%0d[%0d]", v, bad_e), got, mv[v][bad_e]);
    endtask

    task automatic check_mask(input int m, input string req);
        rd_msel = 2'(m);
        #1;
        chk(req, $sformatf("m%0d", m), rd_mask, mm[m]);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R10", "ready", 32'(cmd_ready), 32'd1);
        chk("R10", "done", 32'(done), 32'd0);
        chk("R10", "vl", 32'(vl_now), 32'd32);
        check_vec(3, "R10");
        check_mask(0, "R10");
    endtask

    task automatic t_load;
        for (int e = 0; e < 32; e++) begin
            logic [31:0] x, y;
            x = 32'(e) * 32'h0100_0193 + 32'h7FFF_FFF0;
            y = (e % 3 == 0) ? x : 32'hFFFF_0000 - 32'(e) * 32'd77;
            do_op(4, 0, 0, 1, 0, 0, 0, 0, x, e, "R8");
            do_op(4, 0, 0, 2, 0, 0, 0, 0, y, e, "R8");
        end
        check_vec(1, "R8");
        check_vec(2, "R8");
    endtask

    task automatic t_vv;
        do_op(0, 0, 1, 3, 1, 2, 0, 0, 0, 0, "R1");
        check_vec(3, "R2");
        do_op(1, 0, 1, 4, 1, 2, 0, 0, 0, 0, "R1");
        check_vec(4, "R2");
        do_op(2, 0, 1, 5, 1, 2, 0, 0, 0, 0, "R1");
        check_vec(5, "R2");
    endtask

    task automatic t_sv;
        do_op(5, 0, 0, 0, 0, 0, 0, 0, 16, 0, "R4");
        chk("R4", "vl", 32'(vl_now), 32'd16);
        do_op(2, 1, 1, 6, 0, 2, 0, 0, 32'hFFFF_FFFD, 0, "R1");
        check_vec(6, "R3");
        do_op(1, 1, 1, 6, 0, 1, 0, 0, 32'd5, 0, "R1");
        check_vec(6, "R3");
    endtask

    task automatic t_cmp;
        do_op(5, 0, 0, 0, 0, 0, 0, 0, 32, 0, "R4");
        do_op(3, 0, 0, 0, 1, 2, 0, 1, 0, 0, "R1");
        check_mask(1, "R6");
        do_op(3, 0, 0, 0, 1, 0, 0, 2, 0, 0, "R6");
        check_mask(2, "R6");
        do_op(5, 0, 0, 0, 0, 0, 0, 0, 10, 0, "R4");
        do_op(3, 0, 0, 0, 1, 2, 0, 2, 0, 0, "R1");
        check_mask(2, "R5");
        do_op(3, 1, 0, 0, 0, 1, 0, 3, mv[1][4], 0, "R1");
        check_mask(3, "R6");
    endtask

    task automatic t_mask;
        do_op(5, 0, 0, 0, 0, 0, 0, 0, 32, 0, "R4");
        do_op(1, 0, 0, 5, 1, 2, 1, 0, 0, 0, "R1");
        check_vec(5, "R7");
        do_op(0, 0, 1, 4, 1, 1, 0, 0, 0, 0, "R1");
        check_vec(4, "R7");
    endtask

    task automatic t_vlen;
        do_op(5, 0, 0, 0, 0, 0, 0, 0, 13, 0, "R4");
        chk("R4", "vl", 32'(vl_now), 32'd13);
        do_op(0, 0, 1, 7, 1, 2, 0, 0, 0, 0, "R1");
        check_vec(7, "R5");
        do_op(5, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
        do_op(2, 0, 1, 7, 2, 2, 0, 0, 0, 0, "R1");
        check_vec(7, "R5");
        do_op(4, 0, 0, 7, 0, 0, 0, 0, 32'hCAFE_0031, 31, "R8");
        check_vec(7, "R8");
        do_op(5, 0, 0, 0, 0, 0, 0, 0, 100, 0, "R4");
        chk("R4", "vl clamp", 32'(vl_now), 32'd32);
    endtask

    task automatic t_busy;
        int guard = 0;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_op = 3'd0; cmd_sfrm = 0; cmd_nomask = 1; cmd_vd = 3'd3; cmd_vs1 = 3'd2;
        cmd_vs2 = 3'd5; cmd_valid = 1'b1;
        @(negedge clk);
        chk("R9", "ready while busy", 32'(cmd_ready), 32'd0);
        cmd_op = 3'd5; cmd_scalar = 32'd5;
        @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done && guard < 100) begin @(negedge clk); guard++; end
        model(0, 0, 1, 3, 2, 5, 0, 0, 0, 0);
        @(negedge clk);
        chk("R9", "done width", 32'(done), 32'd0);
        chk("R9", "vl after busy offer", 32'(vl_now), 32'd32);
        check_vec(3, "R9");
    endtask

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_sfrm = 0; cmd_nomask = 0;
        cmd_vd = '0; cmd_vs1 = '0; cmd_vs2 = '0; cmd_msrc = '0; cmd_mdst = '0;
        cmd_scalar = '0; cmd_eidx = '0; rd_vsel = '0; rd_eidx = '0; rd_msel = '0;
        for (int v = 0; v < 8; v++) for (int e = 0; e < 32; e++) mv[v][e] = '0;
        for (int m = 0; m < 4; m++) mm[m] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_load;
        t_vv;
        t_sv;
        t_cmp;
        t_mask;
        t_vlen;
        t_busy;
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule